// File: doc/BRIEF.md
# Prescaled Eight-Bit Timer Counter

This block is an eight-bit up-counter fed through a programmable prescaler. Its ticks come from one of two places. The first is the instruction-cycle enable of the system clock. The second is a chosen transition, rising or falling, on an external counter pin, which is synchronised to the system clock before any edge is detected. A three-bit rate code sets how many ticks the prescaler needs for one counter increment: it needs 2^(code+1) ticks, from 1:2 up to 1:256.

Software sets the source, the pin polarity and the rate through a seven-bit control view. It reads back the counter value and can overwrite it at any time. Each write to the counter also restarts the prescaler, so a fresh interval begins at a known phase. When the counter rolls over from its all-ones value to zero, a single-cycle overflow pulse follows. That pulse can feed an interrupt or event network outside this block.

All ports are plain register-style pins. No stream crosses the boundary, so there is no valid/ready handshake and no back-pressure: every write strobe takes effect at the clock edge that samples it.

Top module: `tick_timer8`

## Requirements
- R1: After reset the counter reads 0x00, the control view reads 0x00 and the overflow pulse is low.
- R2: A control write stores bit 5 (source), bit 4 (pin polarity) and bits 2..0 (rate code), visible on the control read port in the next cycle; bits 6 and 3 always read 0.
- R3: With source bit 0, every clock edge that samples the cycle enable high is one prescaler tick, and activity on the counter pin has no effect on the count.
- R4: With rate code n, the counter advances by one for every 2^(n+1) ticks counted since the last counter write: code 0 is 1:2, code 7 is 1:256.
- R5: With source bit 1 and polarity bit 0, each low-to-high transition of the counter pin is one tick, and the cycle enable has no effect on the count.
- R6: With source bit 1 and polarity bit 1, each high-to-low transition of the counter pin is one tick, and rising transitions are not counted.
- R7: A counter write loads the written value at the next edge, clears the prescaler, and takes priority over an increment due in the same cycle.
- R8: An increment from 0xFF gives 0x00 and raises the overflow pulse for exactly the one cycle after that edge; a counter write never raises it.
- R9: When the rate code is lowered while the prescaler already holds at least the new limit, the next tick increments the counter.
- R10: A pin transition reaches the counter three clock edges after it arrives at the pin: two synchroniser stages and one prescaler/counter edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal tick source |
| ext_pin | input | 1 | External counter pin, asynchronous |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control write data: bit 5 source, bit 4 polarity, bits 2..0 rate code |
| ctl_rdata | output | 7 | Control read data, bits 6 and 3 are 0 |
| cnt_we | input | 1 | Counter write strobe, also clears the prescaler |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_rdata | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse after the counter wraps to zero |

## Verification
The bench uses the default parameters: an eight-bit counter, an eight-bit prescaler and a two-stage synchroniser. These values put every rate code, including the full 1:256 ratio, within reach of short directed runs. Each code is run in all three tick modes, which are internal, rising-pin and falling-pin, and each run stops one tick short of an increment and then supplies that tick. Holding the pin high across the final rising transition separates the two polarities. The eight-bit width also lets a wrap from 0xFE be seen in a few cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CTL_W      = 7;
  localparam int RATE_W     = 3;
  localparam int SRC_BIT    = 5;
  localparam int POL_BIT    = 4;
  localparam int RATE_LSB   = 0;

  typedef struct packed {
    logic              src_pin;   // 1: ticks from the counter pin
    logic              fall_pol;  // 1: count high-to-low transitions
    logic [RATE_W-1:0] rate;      // ratio 1:2^(rate+1)
  } tmr_ctl_t;

  function automatic tmr_ctl_t ctl_decode(input logic [CTL_W-1:0] w);
    tmr_ctl_t c;
    c.src_pin  = w[SRC_BIT];
    c.fall_pol = w[POL_BIT];
    c.rate     = w[RATE_LSB +: RATE_W];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_encode(input tmr_ctl_t c);
    logic [CTL_W-1:0] w;
    w                      = '0;
    w[SRC_BIT]             = c.src_pin;
    w[POL_BIT]             = c.fall_pol;
    w[RATE_LSB +: RATE_W]  = c.rate;
    return w;
  endfunction

endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_pol,
  output logic edge_tick
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign cur = sync_q[STAGES-1];

  always_comb begin
    if (fall_pol) edge_tick = last_q & ~cur;
    else          edge_tick = ~last_q & cur;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              step
);

  localparam int LIM_W = PSC_W + 1;

  logic [PSC_W-1:0] psc_q;
  logic [LIM_W-1:0] limit;
  logic             at_limit;

  // last prescaler value before a step: 2^(rate+1) - 1
  assign limit    = (LIM_W'(2) << rate) - LIM_W'(1);
  assign at_limit = ({1'b0, psc_q} >= limit);
  assign step     = tick & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (clr)    psc_q <= '0;
    else if (tick) begin
      if (at_limit)  psc_q <= '0;
      else           psc_q <= psc_q + PSC_W'(1);
    end
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      wrap  <= 1'b0;
    end else if (load) begin
      value <= load_val;
      wrap  <= 1'b0;
    end else begin
      wrap <= step & (&value);
      if (step) value <= value + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_pin,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             ovf_pulse
);

  tmr_ctl_t ctl_q;
  logic     pin_tick;
  logic     tick;
  logic     step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_decode(ctl_wdata);
  end

  assign ctl_rdata = ctl_encode(ctl_q);

  tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_pin),
    .fall_pol  (ctl_q.fall_pol),
    .edge_tick (pin_tick)
  );

  assign tick = ctl_q.src_pin ? pin_tick : cyc_en;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_we),
    .tick  (tick),
    .rate  (ctl_q.rate),
    .step  (step)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_we),
    .load_val (cnt_wdata),
    .step     (step),
    .value    (cnt_rdata),
    .wrap     (ovf_pulse)
  );

endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [6:0]       ctl_wdata,
  input logic [6:0]       ctl_rdata,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             ovf_pulse
);

  AST_CTL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6] == 1'b0) && (ctl_rdata[3] == 1'b0)); // R2

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata == ($past(ctl_wdata) & 7'h37))); // R2

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_rdata == $past(cnt_wdata))); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> ((cnt_rdata == $past(cnt_rdata)) ||
                 (cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1)))); // R4

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt_rdata == '0)); // R8

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R8

  AST_NO_OVF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !ovf_pulse); // R8

endmodule

bind tick_timer8 tick_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .cnt_rdata (cnt_rdata),
  .ovf_pulse (ovf_pulse)
);

// File: tb/tb_tick_timer8.sv
`timescale 1ns/1ps
module tb_tick_timer8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [6:0] ctl_rdata;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_rdata;
  logic       ovf_pulse;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  tick_timer8 dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ovf_pulse(ovf_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    check(cnt_rdata == 8'(exp), req, int'(cnt_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [6:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  // n internal ticks while the pin toggles every cycle (must be ignored, R3)
  task automatic int_ticks(input int n);
    @(negedge clk); cyc_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = ~ext_pin;
    end
    cyc_en = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; idle(2);
      ext_pin = 1'b0; idle(2);
    end
  endtask

  task automatic t_reset;
    chk_cnt("R1 counter", 0);
    check(ctl_rdata == 7'h00, "R1 control", int'(ctl_rdata), 0);
    check(ovf_pulse == 1'b0, "R1 overflow", int'(ovf_pulse), 0);
  endtask

  task automatic t_ctl;
    wr_ctl(7'h7F);
    check(ctl_rdata == 7'h37, "R2 all ones", int'(ctl_rdata), 'h37);
    wr_ctl(7'h48);
    check(ctl_rdata == 7'h00, "R2 spare bits", int'(ctl_rdata), 0);
  endtask

  // R3/R4: internal source, 4*ratio-1 ticks give 3, one more gives 4
  task automatic t_internal(input logic [2:0] code);
    int ratio;
    ratio = 2 << code;
    ext_pin = 1'b0; idle(4);
    wr_ctl({4'b0000, code});
    wr_cnt(8'h00);
    int_ticks(4 * ratio - 1);
    chk_cnt($sformatf("R4 R3 int code %0d short", code), 3);
    int_ticks(1);
    chk_cnt($sformatf("R4 R3 int code %0d full", code), 4);
    ext_pin = 1'b0; idle(4);
  endtask

  // R5/R6/R10: pin source, cycle enable held high to show it is ignored
  task automatic t_external(input logic fall, input logic [2:0] code);
    int ratio;
    ratio = 2 << code;
    ext_pin = 1'b0; idle(4);
    wr_ctl({1'b0, 1'b1, fall, 1'b0, code});
    wr_cnt(8'h00);
    @(negedge clk); cyc_en = 1'b1;
    pin_pulses(4 * ratio - 1);
    idle(2);
    chk_cnt($sformatf("R5 R6 pol %0d code %0d short", fall, code), 3);
    ext_pin = 1'b1; idle(3);
    chk_cnt($sformatf("R6 R5 R10 pol %0d code %0d high", fall, code), fall ? 3 : 4);
    ext_pin = 1'b0; idle(3);
    chk_cnt($sformatf("R6 R10 pol %0d code %0d low", fall, code), 4);
    cyc_en = 1'b0;
  endtask

  task automatic t_load_priority;
    wr_ctl(7'h00);
    wr_cnt(8'h00);
    int_ticks(1);
    chk_cnt("R7 one tick", 0);
    @(negedge clk); cyc_en = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h40;
    @(negedge clk); cyc_en = 1'b0; cnt_we = 1'b0;
    chk_cnt("R7 load wins", 'h40);
    int_ticks(1);
    chk_cnt("R7 prescaler cleared", 'h40);
    int_ticks(1);
    chk_cnt("R7 then steps", 'h41);
  endtask

  task automatic t_wrap;
    wr_ctl(7'h00);
    wr_cnt(8'hFE);
    @(negedge clk); cyc_en = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check(ovf_pulse == (i == 4), $sformatf("R8 pulse step %0d", i), int'(ovf_pulse), int'(i == 4));
    end
    cyc_en = 1'b0;
    chk_cnt("R8 wrapped", 0);
    @(negedge clk);
    check(ovf_pulse == 1'b0, "R8 one cycle", int'(ovf_pulse), 0);
    wr_cnt(8'hFF);
    wr_cnt(8'h00);
    check(ovf_pulse == 1'b0, "R8 load no pulse", int'(ovf_pulse), 0);
  endtask

  task automatic t_rate_drop;
    wr_ctl(7'h07);
    wr_cnt(8'h00);
    int_ticks(10);
    chk_cnt("R9 slow rate", 0);
    wr_ctl(7'h00);
    int_ticks(1);
    chk_cnt("R9 immediate step", 1);
    int_ticks(1);
    chk_cnt("R9 new ratio", 1);
    int_ticks(1);
    chk_cnt("R9 new ratio step", 2);
  endtask

  initial begin
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset;
    t_ctl;
    for (int c = 0; c < 8; c++) t_internal(3'(c));
    for (int c = 0; c < 8; c++) t_external(1'b0, 3'(c));
    for (int c = 0; c < 8; c++) t_external(1'b1, 3'(c));
    t_load_priority;
    t_wrap;
    t_rate_drop;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule